// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel. It copies a run of beats from a source address to a destination address through a simple request/acknowledge bus master port. Software writes the channel setup inputs (trigger action, trigger source select, event-output enable, interrupt enables) and pulses a start input with a descriptor pointer. The channel then fetches the descriptor from a dedicated descriptor port. A descriptor holds the two addresses, the increment controls, the step and beat size, the beat count, an event selector, a block action and a link to the next descriptor.

Each beat reads first and writes afterwards. No new read is issued until the write response has returned. Transfers wait for a software or peripheral trigger, and the trigger action decides how much data one trigger releases. The channel follows the chain of linked descriptors and turns itself off after the one whose link is zero. Along the way it sets interrupt flags, pulses an event output, and can be held and released by software or held automatically at the end of a block. The remaining count and the live addresses are visible at all times on status outputs.

Top module: `dma_chan_engine`

## Requirements
- R1: A beat raises `rd_req` and holds it until `rd_ack`. It raises `wr_req` only in the cycle after an error-free read response, and drives `wr_data` equal to the data that was read. `rd_req` and `wr_req` are never high together.
- R2: Descriptor layout, with AW=32 and CW=16: bits 31:0 source, 63:32 destination, 95:64 next link, 111:96 beat count (1 to 65535), 112 source increments, 113 destination increments, 116:114 step code, 118:117 beat size, 120:119 event select, 122:121 block action. Beat size 0 is a byte, 1 a half-word and 2 a word, and it appears on `rd_size`/`wr_size`. A block moves exactly as many beats as the count field gives.
- R3: An incrementing address advances by (1 << beat size) << step code after each beat, so step code 0 advances by one beat. A static address stays the same.
- R4: `trig_act` 2 needs one trigger per beat, 0 needs one trigger per block, and 3 needs one trigger for the whole chain. `trig_src` 0 takes `sw_trig`; any other value takes `per_trig`, and the other trigger input is ignored.
- R5: In per-beat mode, a trigger that arrives while a beat is in flight is held, one deep, and releases the next beat.
- R6: When `evo_en` is 1, `evt_o` pulses for one cycle, after the write response: after every beat for event select 3, after each block's last beat for 1, and after the chain's last beat for 2. Event select 0 or `evo_en` 0 gives no pulse.
- R7: After a block ends, a nonzero link causes the descriptor at that address to be fetched. A zero link sets the transaction-complete flag (bit 1) and drops `active`. While `active` is low, no bus request is made.
- R8: A `suspend_req` pulse while active stops the channel before the next beat, sets the suspended flag (bit 3) and holds the bus quiet. A `resume_req` pulse continues the chain from the beat where it stopped.
- R9: Block action bit 0 sets the block-done flag (bit 2) at each block end. Block action bit 1 suspends the channel before the next block begins.
- R10: An error response on a read or a write sets the error flag (bit 0), ends the beat without any write that follows it, and drops `active`.
- R11: Each flag is cleared by writing 1 to its bit of `flag_clr`. `irq` is high while any flag is set whose bit in `int_en` is 1.
- R12: `wb_cnt`, `wb_src` and `wb_dst` show the remaining beat count and the current addresses. After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_start | input | 1 | Start pulse, taken when idle |
| desc_ptr | input | AW | Address of the first descriptor |
| trig_act | input | 2 | Trigger action code |
| trig_src | input | 5 | Trigger source select, 0 = software |
| sw_trig | input | 1 | Software trigger pulse |
| per_trig | input | 1 | Peripheral trigger pulse |
| evo_en | input | 1 | Event output enable |
| suspend_req | input | 1 | Suspend pulse |
| resume_req | input | 1 | Resume pulse |
| int_en | input | 4 | Interrupt enable per flag |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | AW | Descriptor fetch address |
| desc_ack | input | 1 | Descriptor fetch response |
| desc_data | input | DESC_W | Fetched descriptor |
| rd_req | output | 1 | Source read request |
| rd_addr | output | AW | Source read address |
| rd_size | output | 2 | Read beat size |
| rd_ack | input | 1 | Read response |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| rd_data | input | DW | Read data, right-justified |
| wr_req | output | 1 | Destination write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write beat size |
| wr_data | output | DW | Write data, right-justified |
| wr_ack | input | 1 | Write response |
| wr_err | input | 1 | Write error, qualified by wr_ack |
| active | output | 1 | Channel enabled |
| flags | output | 4 | Flags: 0 error, 1 transaction done, 2 block done, 3 suspended |
| irq | output | 1 | Interrupt request |
| evt_o | output | 1 | Event strobe |
| wb_cnt | output | CW | Remaining beats |
| wb_src | output | AW | Current source address |
| wb_dst | output | AW | Current destination address |

## Verification
A wrong count, step or beat-size state in the channel shows up at the write port on the very beat that uses it, as a wrong address, size or data word against the bench's expected sequence. Lost or spurious trigger state appears as a write that comes too early or a chain that stalls, and it is caught within the few cycles a beat takes. Linking and suspend state errors show up as a missing or extra descriptor fetch and a wrong flag word once the channel goes idle.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int CTL_W = 11;

    localparam logic [1:0] TA_BLOCK = 2'd0;
    localparam logic [1:0] TA_BEAT  = 2'd2;
    localparam logic [1:0] TA_CHAIN = 2'd3;

    localparam logic [1:0] EV_OFF   = 2'd0;
    localparam logic [1:0] EV_BLOCK = 2'd1;
    localparam logic [1:0] EV_CHAIN = 2'd2;
    localparam logic [1:0] EV_BEAT  = 2'd3;

    localparam int FL_ERR  = 0;
    localparam int FL_DONE = 1;
    localparam int FL_BLK  = 2;
    localparam int FL_SUSP = 3;
    localparam int NFLAG   = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_READ, ST_WRITE, ST_SUSP
    } dma_st_e;

    // LSB first: src_inc is bit 0 of the control field
    typedef struct packed {
        logic [1:0] blkact;
        logic [1:0] evsel;
        logic [1:0] bsize;
        logic [2:0] step;
        logic       dst_inc;
        logic       src_inc;
    } dma_ctl_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic          inc_i,
    input  logic [1:0]    bsize_i,
    input  logic [2:0]    step_i,
    output logic [AW-1:0] addr_o
);
    logic [3:0] shamt;
    always_comb begin
        shamt  = {2'b00, bsize_i} + {1'b0, step_i};
        addr_o = inc_i ? addr_i + (AW'(1) << shamt) : addr_i;
    end
endmodule

// File: rtl/dma_trig_unit.sv
module dma_trig_unit #(
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [SW-1:0] src_i,
    input  logic          sw_i,
    input  logic          per_i,
    input  logic          take_i,
    output logic          pend_o
);
    logic pend_d, pend_q, hit;
    always_comb begin
        hit    = (src_i == '0) ? sw_i : per_i;
        pend_d = clear_i ? 1'b0 : (hit | (pend_q & ~take_i));
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end
    assign pend_o = pend_q;
endmodule

// File: rtl/dma_flag_unit.sv
module dma_flag_unit #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic [NF-1:0] en_i,
    output logic [NF-1:0] flags_o,
    output logic          irq_o
);
    logic [NF-1:0] fl_d, fl_q;
    always_comb fl_d = (fl_q & ~clr_i) | set_i;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end
    assign flags_o = fl_q;
    assign irq_o   = |(fl_q & en_i);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int SW = 5,
    localparam int CB = 3 * AW + CW,
    localparam int DESC_W = CB + CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_start,
    input  logic [AW-1:0]     desc_ptr,
    input  logic [1:0]        trig_act,
    input  logic [SW-1:0]     trig_src,
    input  logic              sw_trig,
    input  logic              per_trig,
    input  logic              evo_en,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [NFLAG-1:0]  int_en,
    input  logic [NFLAG-1:0]  flag_clr,
    output logic              desc_req,
    output logic [AW-1:0]     desc_addr,
    input  logic              desc_ack,
    input  logic [DESC_W-1:0] desc_data,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [1:0]        wr_size,
    output logic [DW-1:0]     wr_data,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              active,
    output logic [NFLAG-1:0]  flags,
    output logic              irq,
    output logic              evt_o,
    output logic [CW-1:0]     wb_cnt,
    output logic [AW-1:0]     wb_src,
    output logic [AW-1:0]     wb_dst
);
    typedef struct packed {
        dma_st_e       st;
        logic [AW-1:0] cur;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] nxt;
        logic [CW-1:0] cnt;
        dma_ctl_t      ctl;
        logic [DW-1:0] data;
        logic          armed;
        logic          spend;
        logic          evt;
    } regs_t;

    regs_t q, n;
    logic [NFLAG-1:0] fl_set;
    logic             take, pend, last_beat, ev_hit;
    logic [AW-1:0]    side_cur [2];
    logic [AW-1:0]    side_nxt [2];
    logic             side_inc [2];

    assign side_cur[0] = q.src;
    assign side_cur[1] = q.dst;
    assign side_inc[0] = q.ctl.src_inc;
    assign side_inc[1] = q.ctl.dst_inc;

    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_addr_step #(.AW(AW)) step_i (
            .addr_i (side_cur[g]),
            .inc_i  (side_inc[g]),
            .bsize_i(q.ctl.bsize),
            .step_i (q.ctl.step),
            .addr_o (side_nxt[g])
        );
    end

    dma_trig_unit #(.SW(SW)) trig_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(q.st == ST_IDLE),
        .src_i  (trig_src),
        .sw_i   (sw_trig),
        .per_i  (per_trig),
        .take_i (take),
        .pend_o (pend)
    );

    dma_flag_unit #(.NF(NFLAG)) flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fl_set),
        .clr_i  (flag_clr),
        .en_i   (int_en),
        .flags_o(flags),
        .irq_o  (irq)
    );

    always_comb begin
        n         = q;
        n.evt     = 1'b0;
        fl_set    = '0;
        take      = 1'b0;
        desc_req  = 1'b0;
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        last_beat = (q.cnt == CW'(1));
        ev_hit    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                n.armed = 1'b0;
                n.spend = 1'b0;
                if (ch_start) begin
                    n.cur = desc_ptr;
                    n.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                desc_req = 1'b1;
                if (desc_ack) begin
                    n.src = desc_data[AW-1:0];
                    n.dst = desc_data[2*AW-1:AW];
                    n.nxt = desc_data[3*AW-1:2*AW];
                    n.cnt = desc_data[CB-1:3*AW];
                    n.ctl = desc_data[CB+CTL_W-1:CB];
                    n.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (q.spend) begin
                    n.st = ST_SUSP;
                    fl_set[FL_SUSP] = 1'b1;
                end else if (q.armed || pend) begin
                    take    = !q.armed;
                    n.armed = (trig_act != TA_BEAT);
                    n.st    = ST_READ;
                end
            end
            ST_READ: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (rd_err) begin
                        fl_set[FL_ERR] = 1'b1;
                        n.st = ST_IDLE;
                    end else begin
                        n.data = rd_data;
                        n.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                wr_req = 1'b1;
                if (wr_ack) begin
                    if (wr_err) begin
                        fl_set[FL_ERR] = 1'b1;
                        n.st = ST_IDLE;
                    end else begin
                        n.src = side_nxt[0];
                        n.dst = side_nxt[1];
                        n.cnt = q.cnt - CW'(1);
                        ev_hit = (q.ctl.evsel == EV_BEAT);
                        if (!last_beat) begin
                            n.st = ST_WAIT;
                        end else begin
                            ev_hit = ev_hit || (q.ctl.evsel == EV_BLOCK) ||
                                     ((q.nxt == '0) && (q.ctl.evsel == EV_CHAIN));
                            fl_set[FL_BLK] = q.ctl.blkact[0];
                            if (q.nxt == '0) begin
                                fl_set[FL_DONE] = 1'b1;
                                n.st = ST_IDLE;
                            end else begin
                                n.spend = q.spend | q.ctl.blkact[1];
                                n.cur   = q.nxt;
                                n.st    = ST_FETCH;
                                if (trig_act == TA_BLOCK) n.armed = 1'b0;
                            end
                        end
                        n.evt = evo_en && ev_hit;
                    end
                end
            end
            ST_SUSP: begin
                if (!q.spend) n.st = ST_WAIT;
            end
            default: n.st = ST_IDLE;
        endcase
        if (q.st != ST_IDLE && n.st != ST_IDLE) begin
            if (resume_req)  n.spend = 1'b0;
            if (suspend_req) n.spend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign desc_addr = q.cur;
    assign rd_addr   = q.src;
    assign rd_size   = q.ctl.bsize;
    assign wr_addr   = q.dst;
    assign wr_size   = q.ctl.bsize;
    assign wr_data   = q.data;
    assign active    = (q.st != ST_IDLE);
    assign evt_o     = q.evt;
    assign wb_cnt    = q.cnt;
    assign wb_src    = q.src;
    assign wb_dst    = q.dst;
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_req,
    input logic       rd_ack,
    input logic       rd_err,
    input logic       wr_req,
    input logic       wr_ack,
    input logic       evt_o,
    input logic       active,
    input logic [3:0] flags
);
    AST_NO_BUS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R1
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rd_req && rd_ack && !rd_err)); // R1
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req); // R1
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!rd_req && !wr_req)); // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(wr_req && wr_ack)); // R7
    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> (!rd_req && !wr_req)); // R8
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> (!wr_req && !active)); // R10
endmodule

bind dma_chan_engine dma_chan_checker chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .rd_ack(rd_ack),
    .rd_err(rd_err),
    .wr_req(wr_req),
    .wr_ack(wr_ack),
    .evt_o (evt_o),
    .active(active),
    .flags (flags)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb_top;
    localparam int AW = 32, DW = 32, CW = 16;
    localparam int DESC_W = 3 * AW + CW + 11;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              ch_start = 0, sw_trig = 0, per_trig = 0, evo_en = 0;
    logic              suspend_req = 0, resume_req = 0;
    logic [AW-1:0]     desc_ptr = '0;
    logic [1:0]        trig_act = 2'd3;
    logic [4:0]        trig_src = '0;
    logic [3:0]        int_en = '0, flag_clr = '0;
    logic              desc_req, rd_req, wr_req, active, irq, evt_o;
    logic [AW-1:0]     desc_addr, rd_addr, wr_addr, wb_src, wb_dst;
    logic [1:0]        rd_size, wr_size;
    logic [DW-1:0]     wr_data;
    logic [3:0]        flags;
    logic [CW-1:0]     wb_cnt;
    logic              desc_ack = 0, rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
    logic [DESC_W-1:0] desc_data = '0;
    logic [DW-1:0]     rd_data = '0;

    dma_chan_engine dut_i (.*);

    int total = 0, bad = 0, wr_cnt = 0, ev_cnt = 0, cyc = 0;
    logic [7:0]        mem [0:4095];
    logic [DESC_W-1:0] dtab [0:15];
    logic [AW-1:0]     err_addr = 32'hFFFF_FFFF;
    logic [AW+DW+1:0]  expq [$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mread(input logic [AW-1:0] a, input int nb);
        logic [DW-1:0] v = '0;
        for (int i = 0; i < nb; i++) v[8*i +: 8] = mem[(a + i) & 32'hFFF];
        return v;
    endfunction

    function automatic logic [DESC_W-1:0] mk(input logic [31:0] s, d, nx, input int cnt,
            input bit si, di, input int stp, bs, ev, ba);
        logic [DESC_W-1:0] v;
        v = {2'(ba), 2'(ev), 2'(bs), 3'(stp), di, si, 16'(cnt), nx, d, s};
        return v;
    endfunction

    // behavioural reference: walk the chain and list every write it must issue
    task automatic build_exp(input logic [31:0] ptr, input int limit);
        logic [31:0] p = ptr;
        int made = 0;
        expq.delete();
        while (p != 0 && made < limit) begin
            logic [DESC_W-1:0] d = dtab[p[11:8]];
            logic [31:0] s = d[31:0], t = d[63:32];
            int nb = 1 << d[118:117];
            int inc = nb << d[116:114];
            for (int i = 0; i < d[111:96] && made < limit; i++) begin
                expq.push_back({d[118:117], t, mread(s, nb)});
                if (d[112]) s += inc;
                if (d[113]) t += inc;
                made++;
            end
            p = d[95:64];
        end
    endtask

    // bus and descriptor responders; every write is compared with the model
    always @(negedge clk) begin
        desc_ack <= desc_req && !desc_ack;
        if (desc_req && !desc_ack) desc_data <= dtab[desc_addr[11:8]];
        rd_ack <= rd_req && !rd_ack;
        rd_err <= rd_req && !rd_ack && (rd_addr == err_addr);
        if (rd_req && !rd_ack) rd_data <= mread(rd_addr, 1 << rd_size);
        wr_ack <= wr_req && !wr_ack;
        wr_err <= 1'b0;
        if (wr_req && !wr_ack) begin
            logic [AW+DW+1:0] e;
            wr_cnt++;
            if (expq.size() == 0) chk(0, "R1 unexpected write", wr_addr, 0);
            else begin
                e = expq.pop_front();
                chk(wr_addr == e[AW+DW-1:DW], "R3 write address", wr_addr, e[AW+DW-1:DW]);
                chk(wr_size == e[AW+DW+1:AW+DW], "R2 write size", wr_size, e[AW+DW+1:AW+DW]);
                chk(wr_data == e[DW-1:0], "R1 write data", wr_data, e[DW-1:0]);
            end
            for (int i = 0; i < (1 << wr_size); i++) mem[(wr_addr + i) & 32'hFFF] = wr_data[8*i +: 8];
        end
        if (evt_o) ev_cnt++;
        chk(!(rd_req && wr_req), "R1 overlap", 1, 0);
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic pulse_sw();    sw_trig = 1; @(negedge clk); sw_trig = 0; endtask
    task automatic pulse_per();   per_trig = 1; @(negedge clk); per_trig = 0; endtask

    task automatic start(input logic [31:0] p);
        wr_cnt = 0; ev_cnt = 0;
        flag_clr = 4'hF; @(negedge clk); flag_clr = 0;
        desc_ptr = p; ch_start = 1; @(negedge clk); ch_start = 0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (active && k < 3000) begin @(negedge clk); k++; end
        cycles(2);
        chk(!active, req, active, 0);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 16; i++) dtab[i] = '0;
        cycles(3);
        chk(!active && flags == 0 && !irq && !rd_req && !wr_req && !evt_o, "R12 reset state", flags, 0);
        rst_n = 1; cycles(2);

        // T1: word copy, both incrementing, per-beat events, one trigger for the chain
        dtab[1] = mk(32'h400, 32'h800, 0, 4, 1, 1, 0, 2, 3, 0);
        build_exp(32'h100, 1000);
        trig_act = 2'd3; trig_src = 0; evo_en = 1; int_en = 4'b0010;
        start(32'h100); pulse_sw();
        wait_idle("R7 chain end");
        chk(flags == 4'b0010, "R7 done flag", flags, 4'b0010);
        chk(ev_cnt == 4, "R6 beat events", ev_cnt, 4);
        chk(irq, "R11 irq", irq, 1);
        chk(wb_cnt == 0 && wb_src == 32'h410, "R12 final status", wb_src, 32'h410);
        flag_clr = 4'b0010; @(negedge clk); flag_clr = 0; @(negedge clk);
        chk(flags == 0 && !irq, "R11 write one to clear", flags, 0);

        // T2: linked blocks, one trigger per block, block events
        dtab[2] = mk(32'h500, 32'h900, 32'h300, 3, 1, 0, 2, 0, 1, 1);
        dtab[3] = mk(32'h600, 32'hA00, 0, 2, 1, 1, 0, 1, 1, 1);
        build_exp(32'h200, 1000);
        trig_act = 2'd0;
        start(32'h200); pulse_sw();
        cycles(30);
        chk(wr_cnt == 3 && active, "R4 block waits for trigger", wr_cnt, 3);
        pulse_sw();
        wait_idle("R7 link fetch");
        chk(wr_cnt == 5, "R2 beat count", wr_cnt, 5);
        chk(ev_cnt == 2, "R6 block events", ev_cnt, 2);
        chk(flags == 4'b0110, "R9 block flag", flags, 4'b0110);

        // T3: per-beat peripheral trigger, software trigger ignored, one-deep pending
        dtab[4] = mk(32'h700, 32'hB00, 0, 3, 0, 1, 1, 1, 2, 0);
        build_exp(32'h400, 1000);
        trig_act = 2'd2; trig_src = 5'd1;
        start(32'h400); pulse_sw(); cycles(10);
        chk(wr_cnt == 0, "R4 other trigger ignored", wr_cnt, 0);
        pulse_per(); @(negedge clk); pulse_per();
        cycles(20);
        chk(wr_cnt == 2 && active, "R5 pending trigger", wr_cnt, 2);
        pulse_per();
        wait_idle("R4 per beat");
        chk(ev_cnt == 1, "R6 chain event", ev_cnt, 1);

        // T4: software suspend and resume, status while held
        dtab[5] = mk(32'h140, 32'hC00, 0, 6, 1, 1, 0, 2, 3, 0);
        build_exp(32'h500, 1000);
        trig_act = 2'd3; trig_src = 0; evo_en = 0;
        start(32'h500); suspend_req = 1; sw_trig = 1; @(negedge clk); suspend_req = 0; sw_trig = 0;
        cycles(20);
        chk(wr_cnt == 0 && flags[3] && active, "R8 suspended", wr_cnt, 0);
        chk(wb_cnt == 6 && wb_src == 32'h140 && wb_dst == 32'hC00, "R12 status held", wb_cnt, 6);
        resume_req = 1; @(negedge clk); resume_req = 0;
        wait_idle("R8 resume");
        chk(wr_cnt == 6, "R8 all beats after resume", wr_cnt, 6);
        chk(ev_cnt == 0, "R6 event disabled", ev_cnt, 0);

        // T5: automatic suspend at block end
        dtab[6] = mk(32'h180, 32'hD00, 32'h700, 2, 1, 1, 0, 1, 0, 3);
        dtab[7] = mk(32'h1A0, 32'hD40, 0, 2, 1, 1, 0, 1, 0, 0);
        build_exp(32'h600, 1000);
        start(32'h600); pulse_sw(); cycles(30);
        chk(wr_cnt == 2 && flags == 4'b1100, "R9 auto suspend", flags, 4'b1100);
        resume_req = 1; @(negedge clk); resume_req = 0;
        wait_idle("R9 resume");
        chk(wr_cnt == 4, "R9 second block", wr_cnt, 4);

        // T6: read error on the second beat
        dtab[8] = mk(32'h1C0, 32'hE00, 0, 4, 1, 1, 0, 2, 0, 0);
        build_exp(32'h800, 1);
        err_addr = 32'h1C4; int_en = 4'b0010;
        start(32'h800); pulse_sw();
        wait_idle("R10 abort");
        chk(wr_cnt == 1, "R10 no write after error", wr_cnt, 1);
        chk(flags == 4'b0001, "R10 error flag", flags, 4'b0001);
        chk(!irq, "R11 masked flag", irq, 0);

        finish_run();
    end
endmodule